// File: doc/BRIEF.md
# Staircase Harmonic-Elimination Sequencer

This block turns an electrical phase angle into the output level for one phase of a multilevel inverter. It does not compare against a carrier. It looks up a table of precomputed switching angles. Each positive level has one angle. In the first quarter of the cycle, the level rises by one at each angle. The second quarter mirrors the first about the quarter point. The second half-cycle is the negation of the first half. This gives an odd staircase with quarter-wave symmetry. The waveform is referenced to the positive-going zero crossing of the fundamental. Optional notch pulses can be added. Each notch is a pair of angles, and between them the level steps down by one before it returns.

The phase comes from an external accumulator as a 16-bit unsigned code that spans one full cycle. Angles are written one at a time into a shadow table and then committed. The commit checks the ordering. A valid table waits and is swapped in only at the next positive-going zero crossing, so no cycle uses two tables. An invalid table raises an error flag and the table in use stays as it was. The output is a registered signed level together with a one-cycle strobe on every change. Mapping levels to gate signals is done downstream.

Top module: `stair_seq`

## Requirements
- R1: In quadrant 0 (phase bits 15:14 = 00), the level one clock after the phase is applied equals the number of level angles that are less than or equal to the low 14 phase bits (the offset).
- R2: In quadrant 1 (bits 15:14 = 01), the level equals the quadrant 0 value at offset 16384 minus the low 14 bits. The edge for angle a therefore falls at phase code 32768 - a.
- R3: For a phase code p of 32768 or more, the level is the negation of the level at p - 32768.
- R4: Notch k has a start angle s and an end angle e. Wherever the folded offset x satisfies s <= x < e, the notch lowers the level by one. With s = e the notch has no effect.
- R5: `level` is registered and follows the phase with one clock of latency. `level_stb` is high for exactly the clock in which `level` takes a new value, and is low otherwise.
- R6: While `en` is low, `level` is driven to 0 on the next clock.
- R7: A write with `ld_we` stores `ld_angle` at `ld_addr` in a shadow table. Addresses 0 to NUM_POS-1 hold the level angles in ascending order. Address NUM_POS+2k holds the start of notch k and address NUM_POS+2k+1 holds its end. A valid commit takes effect only from the first clock at which the phase moves from quadrant 3 to quadrant 0.
- R8: On `ld_commit`, if the level angles are not strictly ascending, or any notch start exceeds its end, `tbl_err` goes high on the next clock and the table in use and the pending table stay unchanged. A later valid commit clears `tbl_err`.
- R9: Reset clears `level`, `level_stb` and `tbl_err`. It loads level angle i as (i+1)*16384/(NUM_POS+1) and sets every notch edge to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Output enable; when low the level is forced to 0 |
| phase | input | 16 | Electrical phase code covering one full cycle |
| ld_we | input | 1 | Shadow table write strobe |
| ld_addr | input | $clog2(NUM_POS+2*NUM_NOTCH) | Shadow table entry index |
| ld_angle | input | 14 | Angle code written to the shadow entry |
| ld_commit | input | 1 | Validate the shadow table and queue it |
| level | output | LVL_W | Signed output level |
| level_stb | output | 1 | One-cycle pulse on each level change |
| tbl_err | output | 1 | Last commit was rejected for bad ordering |

## Verification
The assertions assume that the phase input only moves from quadrant 3 to quadrant 0 when a real cycle wraps. They also assume that `ld_commit` is never pulsed in the same clock as a shadow write, because that would make the staged contents depend on write ordering. The stimulus applies phase codes one at a time and crosses zero only by going from a quadrant-3 code directly to a quadrant-0 code. Table writes and commits are issued in separate clocks, and all of them happen while the phase sits in quadrant 0. This keeps any table swap at a single well-defined clock.

// File: rtl/stair_pkg.sv
package stair_pkg;
  // phase code spans one electrical cycle
  localparam int PHASE_W = 16;
  // angle codes address one quarter cycle
  localparam int QTR_W = PHASE_W - 2;
  // folded offset needs one more bit to reach the quarter point itself
  localparam int OFF_W = QTR_W + 1;
endpackage

// File: rtl/stair_tbl.sv
module stair_tbl
  import stair_pkg::*;
#(
  parameter int NUM_POS   = 2,
  parameter int NUM_NOTCH = 1,
  localparam int ENT = NUM_POS + 2 * NUM_NOTCH,
  localparam int AW  = (ENT > 1) ? $clog2(ENT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [QTR_W-1:0]     wdata,
  input  logic                 commit,
  input  logic                 xing,
  output logic [ENT*QTR_W-1:0] act_flat,
  output logic [ENT*QTR_W-1:0] stg_flat,
  output logic [ENT*QTR_W-1:0] use_flat,
  output logic                 err
);
  logic [QTR_W-1:0] shd [ENT];
  logic [QTR_W-1:0] stg [ENT];
  logic [QTR_W-1:0] act [ENT];
  logic pend;
  logic shd_ok;
  logic swap;

  function automatic logic [QTR_W-1:0] dflt(input int i);
    if (i < NUM_POS) return QTR_W'(((i + 1) * (1 << QTR_W)) / (NUM_POS + 1));
    return '0;
  endfunction

  // ordering rule: level angles strictly rising, each notch start <= end
  always_comb begin
    shd_ok = 1'b1;
    for (int i = 1; i < NUM_POS; i++)
      if (shd[i] <= shd[i-1]) shd_ok = 1'b0;
    for (int k = 0; k < NUM_NOTCH; k++)
      if (shd[NUM_POS + 2*k] > shd[NUM_POS + 2*k + 1]) shd_ok = 1'b0;
  end

  assign swap = xing & pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin
        shd[i] <= dflt(i);
        stg[i] <= dflt(i);
        act[i] <= dflt(i);
      end
      pend <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (we && int'(addr) < ENT) shd[addr] <= wdata;
      if (swap) begin
        for (int i = 0; i < ENT; i++) act[i] <= stg[i];
        pend <= 1'b0;
      end
      if (commit) begin
        if (shd_ok) begin
          for (int i = 0; i < ENT; i++) stg[i] <= shd[i];
          pend <= 1'b1;
          err  <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < ENT; g++) begin : g_flat
    assign act_flat[g*QTR_W +: QTR_W] = act[g];
    assign stg_flat[g*QTR_W +: QTR_W] = stg[g];
  end

  // the crossing clock already evaluates with the incoming table
  assign use_flat = swap ? stg_flat : act_flat;
endmodule

// File: rtl/stair_eval.sv
module stair_eval
  import stair_pkg::*;
#(
  parameter int NUM_POS   = 2,
  parameter int NUM_NOTCH = 1,
  parameter int LVL_W     = 3,
  localparam int ENT = NUM_POS + 2 * NUM_NOTCH
) (
  input  logic [PHASE_W-1:0]      phase,
  input  logic [ENT*QTR_W-1:0]    tbl,
  output logic signed [LVL_W-1:0] lvl
);
  // fold the phase onto the first quarter; odd quarters are mirrored
  function automatic logic [OFF_W-1:0] fold(input logic [PHASE_W-1:0] p);
    if (p[QTR_W]) return (OFF_W'(1) << QTR_W) - OFF_W'(p[QTR_W-1:0]);
    return OFF_W'(p[QTR_W-1:0]);
  endfunction

  logic [OFF_W-1:0]        q;
  logic signed [LVL_W-1:0] cnt;

  always_comb begin
    q   = fold(phase);
    cnt = '0;
    for (int i = 0; i < NUM_POS; i++)
      if (OFF_W'(tbl[i*QTR_W +: QTR_W]) <= q) cnt = cnt + LVL_W'(1);
    for (int k = 0; k < NUM_NOTCH; k++)
      if (OFF_W'(tbl[(NUM_POS+2*k)*QTR_W +: QTR_W]) <= q &&
          q < OFF_W'(tbl[(NUM_POS+2*k+1)*QTR_W +: QTR_W]))
        cnt = cnt - LVL_W'(1);
    lvl = phase[PHASE_W-1] ? -cnt : cnt;
  end
endmodule

// File: rtl/stair_seq.sv
module stair_seq
  import stair_pkg::*;
#(
  parameter int NUM_POS   = 2,
  parameter int NUM_NOTCH = 1,
  localparam int ENT   = NUM_POS + 2 * NUM_NOTCH,
  localparam int AW    = (ENT > 1) ? $clog2(ENT) : 1,
  localparam int LVL_W = $clog2(NUM_POS + NUM_NOTCH + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [PHASE_W-1:0]      phase,
  input  logic                    ld_we,
  input  logic [AW-1:0]           ld_addr,
  input  logic [QTR_W-1:0]        ld_angle,
  input  logic                    ld_commit,
  output logic signed [LVL_W-1:0] level,
  output logic                    level_stb,
  output logic                    tbl_err
);
  logic [1:0]              prev_quad;
  logic                    xing;
  logic [ENT*QTR_W-1:0]    act_flat;
  logic [ENT*QTR_W-1:0]    stg_flat;
  logic [ENT*QTR_W-1:0]    use_flat;
  logic signed [LVL_W-1:0] lvl_c;
  logic signed [LVL_W-1:0] lvl_nxt;

  // positive-going zero crossing: last quadrant straight into the first
  assign xing = (prev_quad == 2'b11) && (phase[PHASE_W-1 -: 2] == 2'b00);

  stair_tbl #(.NUM_POS(NUM_POS), .NUM_NOTCH(NUM_NOTCH)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(ld_we), .addr(ld_addr), .wdata(ld_angle),
    .commit(ld_commit), .xing(xing), .act_flat(act_flat),
    .stg_flat(stg_flat), .use_flat(use_flat), .err(tbl_err)
  );

  stair_eval #(.NUM_POS(NUM_POS), .NUM_NOTCH(NUM_NOTCH), .LVL_W(LVL_W)) u_eval (
    .phase(phase), .tbl(use_flat), .lvl(lvl_c)
  );

  assign lvl_nxt = en ? lvl_c : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_quad <= 2'b00;
      level     <= '0;
      level_stb <= 1'b0;
    end else begin
      prev_quad <= phase[PHASE_W-1 -: 2];
      level     <= lvl_nxt;
      level_stb <= (lvl_nxt != level);
    end
  end
endmodule

// File: rtl/stair_seq_chk.sv
module stair_seq_chk #(
  parameter int LVL_W = 3,
  parameter int TBL_W = 56,
  parameter int LIM   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic signed [LVL_W-1:0] level,
  input logic                    level_stb,
  input logic                    xing,
  input logic [TBL_W-1:0]        act_flat,
  input logic [TBL_W-1:0]        stg_flat,
  input logic                    tbl_err
);
  p_stb_means_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level_stb |-> level != $past(level));

  p_change_has_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level != $past(level) |-> level_stb);

  p_off_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> level == '0);

  p_level_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) <= LIM) && (int'(level) >= -LIM));

  p_swap_at_crossing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_flat) |-> $past(xing));

  p_reject_keeps_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_err) |-> $stable(stg_flat));
endmodule

bind stair_seq stair_seq_chk #(
  .LVL_W(LVL_W), .TBL_W(ENT * stair_pkg::QTR_W), .LIM(NUM_POS + NUM_NOTCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .level(level), .level_stb(level_stb),
  .xing(xing), .act_flat(act_flat), .stg_flat(stg_flat), .tbl_err(tbl_err)
);

// File: tb/stair_seq_tb.sv
module stair_seq_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [15:0]       phase = '0;
  logic              ld_we = 1'b0;
  logic [1:0]        ld_addr = '0;
  logic [13:0]       ld_angle = '0;
  logic              ld_commit = 1'b0;
  logic signed [2:0] level;
  logic              level_stb;
  logic              tbl_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stair_seq dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .phase(phase), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_angle(ld_angle), .ld_commit(ld_commit),
    .level(level), .level_stb(level_stb), .tbl_err(tbl_err)
  );

  // default table: angles 5461 and 10922, notch empty
  localparam int NV = 13;
  localparam int VPH [NV] = '{0, 5460, 5461, 10922, 16383, 16384, 27307,
                              27308, 32768, 38229, 43690, 49152, 65535};
  localparam int VEX [NV] = '{0, 0, 1, 2, 2, 2, 1, 0, 0, -1, -2, -2, 0};

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int ph);
    phase = 16'(ph);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int v);
    ld_we = 1'b1; ld_addr = 2'(a); ld_angle = 14'(v);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic commit();
    ld_commit = 1'b1;
    @(negedge clk);
    ld_commit = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 level", int'(level), 0);
    check("R9 strobe", int'(level_stb), 0);
    check("R9 err", int'(tbl_err), 0);
    rst_n = 1'b1; en = 1'b1;

    // R1 R2 R3 vector walk over the default table
    for (int i = 0; i < NV; i++) begin
      apply(VPH[i]);
      check("R1/R2/R3 vector", int'(level), VEX[i]);
    end

    // R5 strobe behaviour
    apply(0);
    check("R5 no change no strobe", int'(level_stb), 0);
    apply(5461);
    check("R5 strobe on change", int'(level_stb), 1);
    check("R5 level", int'(level), 1);
    apply(5461);
    check("R5 strobe single cycle", int'(level_stb), 0);

    // R6 enable
    en = 1'b0;
    apply(10922);
    check("R6 disabled level", int'(level), 0);
    en = 1'b1;
    apply(10922);
    check("R6 re-enabled level", int'(level), 2);

    // R7 load angles 2000,8000 with notch 3000..4000
    wr(0, 2000); wr(1, 8000); wr(2, 3000); wr(3, 4000);
    commit();
    check("R8 good commit no err", int'(tbl_err), 0);
    apply(2500);
    check("R7 old table before crossing", int'(level), 0);
    apply(16'hF000);
    check("R7 old table quadrant 3", int'(level), 0);
    apply(2500);
    check("R7 new table at crossing", int'(level), 1);
    apply(3500);
    check("R4 notch lowers level", int'(level), 0);
    apply(4000);
    check("R4 notch end restores", int'(level), 1);
    apply(8000);
    check("R1 top level new table", int'(level), 2);
    apply(32768 - 3500);
    check("R4 notch mirrored", int'(level), 0);
    apply(32768 + 2500);
    check("R3 negative half", int'(level), -1);
    apply(32768 + 3500);
    check("R4 notch negative half", int'(level), 0);

    // R8 bad ordering rejected
    apply(100);
    wr(0, 9000);
    commit();
    check("R8 err raised", int'(tbl_err), 1);
    apply(16'hF000);
    apply(2500);
    check("R8 table kept after crossing", int'(level), 1);
    wr(0, 1000);
    commit();
    check("R8 err cleared", int'(tbl_err), 0);
    apply(16'hF000);
    apply(1500);
    check("R7 second table active", int'(level), 1);

    done = 1'b1;
    report();
  end
endmodule